// File: doc/BRIEF.md
# Programmable Syndrome Residual Array

This block sits on the read path of a flash page decoder. It takes the page as a serial stream, one bit per accepted cycle, and passes every bit to an array of shift-register dividers at once. Each divider holds the remainder of the received word modulo its own minimal polynomial. The polynomial's degree and lower coefficients are loaded at run time, so one array serves several field sizes. The same bits are written into a small page FIFO. A later stage reads the FIFO for correction.

When the last bit of a page has been taken, the block raises a done level and a single error flag. The error flag is high when any active remainder has a non-zero coefficient. A clean page therefore needs no field arithmetic to be recognised. All remainders are visible on one flat output bus, where the downstream syndrome stage can read them. The next page may start as soon as the previous one ends.

The number of units taking part is programmable. Units beyond that count stay at zero and play no part in the error flag.

Top module: `resid_lfsr_array`

## Requirements
- R1: After reset, every residual is zero, page_done and page_err are 0, fifo_empty is 1 and fifo_full is 0.
- R2: Unit i holds its residual in res_flat[i*MAX_DEG +: MAX_DEG], with bit k the coefficient of x^k. After a page, the residual equals the page polynomial modulo x^d + taps, where d is the unit's degree and bit k of taps is the coefficient of x^k. The first bit of the page is the highest power.
- R3: A bit accepted with in_sop clears the prior contents of every residual in that same cycle and is itself taken as the first bit, so back-to-back pages give independent results.
- R4: A configuration write (cfg_we with cfg_idx = i) loads the degree and taps of unit i. A write is ignored if cfg_deg is outside MIN_DEG..MAX_DEG or if cfg_idx is not below NUM_UNITS. Tap bits at or above the degree have no effect, and residual bits at or above the degree are always zero. Each unit resets to degree MAX_DEG with taps equal to 1.
- R5: Unit i is active when i < act_units. An inactive unit holds a zero residual and does not contribute to page_err.
- R6: page_done goes high in the cycle after the cycle where a bit with in_eop is accepted. It stays high until a bit with in_sop is accepted. A bit with both in_sop and in_eop gives a one-bit page.
- R7: page_err is updated together with page_done. It is 1 exactly when some active residual of the finished page is non-zero, and it is 0 whenever page_done is 0.
- R8: Every accepted bit is pushed into the FIFO and is read back in arrival order on fifo_dout, which shows the head entry. A push while the FIFO is full is dropped. A read while it is empty has no effect.
- R9: A cycle with in_valid low leaves all residuals unchanged while act_units is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | CNT_W | Unit selected by the write |
| cfg_deg | input | DEG_W | Polynomial degree to load |
| cfg_taps | input | MAX_DEG | Polynomial coefficients below the leading term |
| act_units | input | CNT_W | Number of active units |
| in_valid | input | 1 | Data bit valid |
| in_bit | input | 1 | Serial page data |
| in_sop | input | 1 | First bit of a page |
| in_eop | input | 1 | Last bit of a page |
| page_done | output | 1 | Residuals of the last page are final |
| page_err | output | 1 | Some active residual is non-zero |
| res_flat | output | NUM_UNITS*MAX_DEG | All residuals, unit 0 in the low bits |
| fifo_rd | input | 1 | Pop the head FIFO entry |
| fifo_dout | output | 1 | Head FIFO entry |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_full | output | 1 | FIFO holds FIFO_DEPTH entries |

## Verification
A wrong feedback tap or a wrong degree mask in one unit spreads through that unit's residual on the next bit after the first set top bit. It then shows as a residual mismatch at the end of almost any random page. Pages built as multiples of the programmed polynomials expose a stuck or miswired error flag, because the expected flag is zero there. A failed clear on a start-of-page shows up only on the second of two back-to-back pages, and a FIFO pointer fault shows up at the first bit read back out of order.

// File: rtl/resid_pkg.sv
package resid_pkg;

   typedef enum logic [1:0] {
      PG_IDLE = 2'd0,
      PG_RUN  = 2'd1,
      PG_DONE = 2'd2
   } page_state_t;

endpackage

// File: rtl/resid_unit.sv
module resid_unit #(
   parameter int unsigned MAX_DEG = 15,
   parameter int unsigned MIN_DEG = 12,
   parameter int unsigned DEG_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [DEG_W-1:0]   cfg_deg,
   input  logic [MAX_DEG-1:0] cfg_taps,
   input  logic               active,
   input  logic               shift_en,
   input  logic               restart,
   input  logic               din,
   output logic [MAX_DEG-1:0] res,
   output logic               nz_next
);
   localparam logic [DEG_W-1:0] DEG_LO = DEG_W'(MIN_DEG);
   localparam logic [DEG_W-1:0] DEG_HI = DEG_W'(MAX_DEG);

   logic [DEG_W-1:0]   deg_q;
   logic [MAX_DEG-1:0] taps_q;
   logic [MAX_DEG-1:0] res_q;
   logic [MAX_DEG-1:0] res_d;
   logic [MAX_DEG-1:0] base;
   logic [MAX_DEG-1:0] mask;
   logic [MAX_DEG-1:0] top_bit;
   logic [MAX_DEG-1:0] shifted;
   logic               fb;
   logic               cfg_ok;

   assign cfg_ok = cfg_we && (cfg_deg >= DEG_LO) && (cfg_deg <= DEG_HI);

   generate
      if (MIN_DEG == MAX_DEG) begin : g_fixed_deg
         assign deg_q = DEG_HI;
      end else begin : g_prog_deg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               deg_q <= DEG_HI;
            end else if (cfg_ok) begin
               deg_q <= cfg_deg;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         taps_q <= MAX_DEG'(1);
      end else if (cfg_ok) begin
         taps_q <= cfg_taps;
      end
   end

   always_comb begin
      for (int k = 0; k < MAX_DEG; k++) begin
         mask[k] = (DEG_W'(k) < deg_q);
      end
   end

   assign top_bit = mask & ~(mask >> 1);
   assign base    = restart ? '0 : res_q;
   assign fb      = |(base & top_bit);
   assign shifted = {base[MAX_DEG-2:0], din} & mask;
   assign res_d   = shifted ^ (fb ? (taps_q & mask) : '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q <= '0;
      end else if (!active) begin
         res_q <= '0;
      end else if (shift_en) begin
         res_q <= res_d;
      end
   end

   assign res     = res_q;
   assign nz_next = active && (|res_d);

endmodule

// File: rtl/resid_page_fifo.sv
module resid_page_fifo #(
   parameter int unsigned WIDTH = 1,
   parameter int unsigned DEPTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             rd,
   output logic [WIDTH-1:0] rdata,
   output logic             empty,
   output logic             full
);
   localparam int unsigned AW = $clog2(DEPTH);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr;
   logic [AW-1:0]    rd_ptr;
   logic [AW:0]      count;
   logic             push;
   logic             pop;

   assign empty = (count == '0);
   assign full  = (count == (AW+1)'(DEPTH));
   assign push  = wr && !full;
   assign pop   = rd && !empty;
   assign rdata = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) begin
         mem[wr_ptr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_ptr + 1'b1;
         if (pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/resid_page_ctrl.sv
module resid_page_ctrl
   import resid_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic in_sop,
   input  logic in_eop,
   input  logic any_nz,
   output logic page_done,
   output logic page_err
);
   page_state_t state_q;
   logic        err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PG_IDLE;
         err_q   <= 1'b0;
      end else if (in_valid && in_eop) begin
         state_q <= PG_DONE;
         err_q   <= any_nz;
      end else if (in_valid && in_sop) begin
         state_q <= PG_RUN;
         err_q   <= 1'b0;
      end
   end

   assign page_done = (state_q == PG_DONE);
   assign page_err  = err_q;

endmodule

// File: rtl/resid_lfsr_array.sv
module resid_lfsr_array #(
   parameter int unsigned NUM_UNITS  = 4,
   parameter int unsigned MAX_DEG    = 15,
   parameter int unsigned MIN_DEG    = 12,
   parameter int unsigned FIFO_DEPTH = 64,
   localparam int unsigned DEG_W     = $clog2(MAX_DEG + 1),
   localparam int unsigned CNT_W     = $clog2(NUM_UNITS + 1),
   localparam int unsigned FLAT_W    = NUM_UNITS * MAX_DEG
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [CNT_W-1:0]   cfg_idx,
   input  logic [DEG_W-1:0]   cfg_deg,
   input  logic [MAX_DEG-1:0] cfg_taps,
   input  logic [CNT_W-1:0]   act_units,
   input  logic               in_valid,
   input  logic               in_bit,
   input  logic               in_sop,
   input  logic               in_eop,
   output logic               page_done,
   output logic               page_err,
   output logic [FLAT_W-1:0]  res_flat,
   input  logic               fifo_rd,
   output logic               fifo_dout,
   output logic               fifo_empty,
   output logic               fifo_full
);

   if (NUM_UNITS < 1) begin : g_bad_units
      $error("NUM_UNITS must be at least 1");
   end
   if (MIN_DEG < 2 || MIN_DEG > MAX_DEG) begin : g_bad_deg
      $error("MIN_DEG must lie in 2..MAX_DEG");
   end
   if (FIFO_DEPTH < 2 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two of at least 2");
   end

   logic [NUM_UNITS-1:0] nz_next;
   logic                 restart;

   assign restart = in_valid && in_sop;

   generate
      for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
         logic unit_we;
         logic unit_active;

         assign unit_we     = cfg_we && (cfg_idx == CNT_W'(i));
         assign unit_active = (CNT_W'(i) < act_units);

         resid_unit #(
            .MAX_DEG (MAX_DEG),
            .MIN_DEG (MIN_DEG),
            .DEG_W   (DEG_W)
         ) u_unit (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (unit_we),
            .cfg_deg  (cfg_deg),
            .cfg_taps (cfg_taps),
            .active   (unit_active),
            .shift_en (in_valid),
            .restart  (restart),
            .din      (in_bit),
            .res      (res_flat[i*MAX_DEG +: MAX_DEG]),
            .nz_next  (nz_next[i])
         );
      end
   endgenerate

   resid_page_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sop    (in_sop),
      .in_eop    (in_eop),
      .any_nz    (|nz_next),
      .page_done (page_done),
      .page_err  (page_err)
   );

   resid_page_fifo #(
      .WIDTH (1),
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (in_valid),
      .wdata (in_bit),
      .rd    (fifo_rd),
      .rdata (fifo_dout),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

endmodule

// File: rtl/resid_lfsr_array_chk.sv
module resid_lfsr_array_chk #(
   parameter int unsigned NUM_UNITS = 4,
   parameter int unsigned MAX_DEG   = 15,
   parameter int unsigned CNT_W     = 3
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          in_valid,
   input logic                          in_sop,
   input logic                          in_eop,
   input logic [CNT_W-1:0]              act_units,
   input logic                          page_done,
   input logic                          page_err,
   input logic [NUM_UNITS*MAX_DEG-1:0]  res_flat,
   input logic                          fifo_rd,
   input logic                          fifo_empty,
   input logic                          fifo_full
);

   AST_EOP_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_eop) |=> page_done); // R6

   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (page_done && !(in_valid && in_sop)) |=> page_done); // R6

   AST_SOP_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sop && !in_eop) |=> !page_done); // R6

   AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      page_err |-> page_done); // R7

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && $stable(act_units)) |=> $stable(res_flat)); // R9

   AST_FIFO_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_full && fifo_empty)); // R8

   AST_FIFO_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && !fifo_rd) |=> fifo_full); // R8

   generate
      for (genvar i = 0; i < NUM_UNITS; i++) begin : g_idle_chk
         AST_INACTIVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (CNT_W'(i) >= act_units) |=> (res_flat[i*MAX_DEG +: MAX_DEG] == '0)); // R5
      end
   endgenerate

endmodule

bind resid_lfsr_array resid_lfsr_array_chk #(
   .NUM_UNITS (NUM_UNITS),
   .MAX_DEG   (MAX_DEG),
   .CNT_W     (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_sop     (in_sop),
   .in_eop     (in_eop),
   .act_units  (act_units),
   .page_done  (page_done),
   .page_err   (page_err),
   .res_flat   (res_flat),
   .fifo_rd    (fifo_rd),
   .fifo_empty (fifo_empty),
   .fifo_full  (fifo_full)
);

// File: tb/resid_lfsr_array_tb_top.sv
`timescale 1ns/100ps
module resid_lfsr_array_tb_top;
   localparam int NU = 4;
   localparam int MD = 15;
   localparam int ND = 12;
   localparam int DEPTH = 64;
   localparam int CW = 3;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            cfg_we;
   logic [CW-1:0]   cfg_idx;
   logic [3:0]      cfg_deg;
   logic [MD-1:0]   cfg_taps;
   logic [CW-1:0]   act_units;
   logic            in_valid, in_bit, in_sop, in_eop;
   logic            page_done, page_err;
   logic [NU*MD-1:0] res_flat;
   logic            fifo_rd, fifo_dout, fifo_empty, fifo_full;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

   int          m_deg  [NU];
   logic [14:0] m_taps [NU];
   int          m_act;
   bit          exp_q [$];

   always #2.5 clk = ~clk;

   resid_lfsr_array #(
      .NUM_UNITS(NU), .MAX_DEG(MD), .MIN_DEG(ND), .FIFO_DEPTH(DEPTH)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_deg(cfg_deg), .cfg_taps(cfg_taps), .act_units(act_units),
      .in_valid(in_valid), .in_bit(in_bit), .in_sop(in_sop), .in_eop(in_eop),
      .page_done(page_done), .page_err(page_err), .res_flat(res_flat),
      .fifo_rd(fifo_rd), .fifo_dout(fifo_dout), .fifo_empty(fifo_empty),
      .fifo_full(fifo_full)
   );

   function automatic logic [63:0] rnd();
      seed ^= seed << 13;
      seed ^= seed >> 7;
      seed ^= seed << 17;
      return seed;
   endfunction

   function automatic logic [63:0] len_mask(int len);
      return (len >= 64) ? '1 : ((64'd1 << len) - 64'd1);
   endfunction

   function automatic logic [63:0] phi_of(int deg, logic [14:0] taps);
      return (64'd1 << deg) | ({49'd0, taps} & len_mask(deg));
   endfunction

   function automatic logic [63:0] clmul(logic [63:0] a, logic [63:0] b);
      logic [63:0] r = '0;
      for (int i = 0; i < 64; i++) if (b[i]) r ^= a << i;
      return r;
   endfunction

   function automatic logic [14:0] ref_rem(logic [63:0] w, int len, int deg, logic [14:0] taps);
      logic [63:0] phi = phi_of(deg, taps);
      for (int i = len - 1; i >= deg; i--) if (w[i]) w ^= phi << (i - deg);
      return w[14:0] & len_mask(deg)[14:0];
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, a, e);
      end
   endtask

   task automatic cfg_write(input int idx, input int deg, input logic [14:0] taps);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = CW'(idx); cfg_deg = 4'(deg); cfg_taps = taps;
      @(negedge clk);
      cfg_we = 1'b0;
      if (idx < NU && deg >= ND && deg <= MD) begin
         m_deg[idx] = deg; m_taps[idx] = taps;
      end
   endtask

   task automatic set_act(input int n);
      @(negedge clk);
      act_units = CW'(n); m_act = n;
   endtask

   task automatic run_page(input logic [63:0] w, input int len, input bit gap, input bit tail);
      for (int i = len - 1; i >= 0; i--) begin
         if (gap && (i % 3 == 1)) begin
            @(negedge clk);
            in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
         end
         @(negedge clk);
         if (i == len - 2) chk(page_done == 1'b0, "R6 done cleared by start", 64'(page_done), 0);
         in_valid = 1'b1; in_bit = w[i]; in_sop = (i == len - 1); in_eop = (i == 0);
         if (exp_q.size() < DEPTH) exp_q.push_back(w[i]);
      end
      if (tail) begin
         @(negedge clk);
         in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
      end
   endtask

   task automatic check_page(input logic [63:0] w, input int len, input string tag);
      bit any = 1'b0;
      for (int i = 0; i < NU; i++) begin
         logic [14:0] e = (i < m_act) ? ref_rem(w, len, m_deg[i], m_taps[i]) : 15'd0;
         logic [14:0] a = res_flat[i*MD +: MD];
         if (e != 0) any = 1'b1;
         chk(a == e, (i < m_act) ? {tag, " R2 residual"} : {tag, " R5 inactive residual"}, 64'(a), 64'(e));
      end
      chk(page_done == 1'b1, {tag, " R6 done"}, 64'(page_done), 1);
      chk(page_err == any, {tag, " R7 err"}, 64'(page_err), 64'(any));
   endtask

   task automatic drain();
      while (exp_q.size() > 0) begin
         chk(!fifo_empty && fifo_dout == exp_q[0], "R8 fifo order", 64'(fifo_dout), 64'(exp_q[0]));
         fifo_rd = 1'b1;
         @(negedge clk);
         void'(exp_q.pop_front());
      end
      chk(fifo_empty == 1'b1, "R8 fifo empty after drain", 64'(fifo_empty), 1);
      @(negedge clk);
      fifo_rd = 1'b0;
      chk(fifo_empty == 1'b1, "R8 empty read ignored", 64'(fifo_empty), 1);
   endtask

   task automatic random_pages(input int count, input string tag);
      for (int p = 0; p < count; p++) begin
         int len = 1 + int'(rnd() % 64);
         logic [63:0] w = rnd() & len_mask(len);
         run_page(w, len, p[0], 1'b1);
         check_page(w, len, tag);
         drain();
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] wa, wb, cw;
      logic [14:0] snap0;
      rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_deg = '0; cfg_taps = '0;
      act_units = CW'(NU); m_act = NU;
      in_valid = 1'b0; in_bit = 1'b0; in_sop = 1'b0; in_eop = 1'b0; fifo_rd = 1'b0;
      for (int i = 0; i < NU; i++) begin m_deg[i] = MD; m_taps[i] = 15'd1; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(res_flat == '0, "R1 residuals zero", 64'(res_flat), 0);
      chk(page_done == 1'b0, "R1 done low", 64'(page_done), 0);
      chk(page_err == 1'b0, "R1 err low", 64'(page_err), 0);
      chk(fifo_empty == 1'b1 && fifo_full == 1'b0, "R1 fifo empty", {62'd0, fifo_full, fifo_empty}, 1);

      // R4 reset configuration (degree MAX_DEG, taps 1)
      random_pages(2, "reset-cfg");

      cfg_write(0, 12, 15'h0053);
      cfg_write(1, 13, 15'h001B);
      cfg_write(2, 14, 15'h0443);
      cfg_write(3, 15, 15'h0003);
      random_pages(10, "base-cfg");

      // R7 multiple of every polynomial: clean page
      cw = clmul(clmul(phi_of(12, 15'h0053), phi_of(13, 15'h001B)),
                 clmul(phi_of(14, 15'h0443), phi_of(15, 15'h0003)));
      cw = clmul(cw, 64'hB);
      run_page(cw, 58, 1'b0, 1'b1);
      check_page(cw, 58, "R7 codeword");
      drain();
      run_page(cw ^ (64'd1 << 20), 58, 1'b1, 1'b1);
      check_page(cw ^ (64'd1 << 20), 58, "R7 one flipped bit");
      drain();

      // R6 R9 done and residuals hold through idle cycles
      wa = rnd() & len_mask(40);
      run_page(wa, 40, 1'b0, 1'b1);
      snap0 = res_flat[0 +: MD];
      repeat (6) @(negedge clk);
      check_page(wa, 40, "R9 idle hold");
      chk(res_flat[0 +: MD] == snap0, "R9 unit0 stable", 64'(res_flat[0 +: MD]), 64'(snap0));
      drain();

      // R3 back-to-back pages
      wa = rnd() & len_mask(30);
      wb = rnd() & len_mask(25);
      run_page(wa, 30, 1'b0, 1'b0);
      run_page(wb, 25, 1'b0, 1'b1);
      check_page(wb, 25, "R3 second page");
      drain();

      // R6 one-bit pages (start and end together)
      run_page(64'd1, 1, 1'b0, 1'b1);
      check_page(64'd1, 1, "R6 one-bit one");
      drain();
      run_page(64'd0, 1, 1'b0, 1'b1);
      check_page(64'd0, 1, "R6 one-bit zero");
      drain();

      // R5 fewer active units
      set_act(2);
      cw = clmul(clmul(phi_of(12, 15'h0053), phi_of(13, 15'h001B)), 64'h25);
      run_page(cw, 31, 1'b0, 1'b1);
      check_page(cw, 31, "R5 two active");
      drain();
      set_act(4);
      run_page(cw, 31, 1'b0, 1'b1);
      check_page(cw, 31, "R5 four active");
      drain();
      set_act(1);
      random_pages(3, "R5 one active");
      set_act(4);

      // R4 illegal writes ignored, then reprogramming
      cfg_write(0, 11, 15'h7FFF);
      cfg_write(5, 12, 15'h0001);
      random_pages(3, "R4 after illegal writes");
      cfg_write(0, 15, 15'h0003);
      cfg_write(1, 12, 15'h7FD3);
      cfg_write(2, 13, 15'h601B);
      cfg_write(3, 14, 15'h0443);
      random_pages(8, "R4 rotated cfg");

      // R8 overflow: 70 pushes, only the first DEPTH kept
      wa = rnd();
      wb = rnd() & len_mask(6);
      run_page({wb[5:0], wa[63:6]}, 64, 1'b0, 1'b0);
      run_page(wa & len_mask(6), 6, 1'b0, 1'b1);
      chk(fifo_full == 1'b1, "R8 fifo full", 64'(fifo_full), 1);
      check_page(wa & len_mask(6), 6, "R8 page after overflow");
      drain();
      run_page(64'd1, 1, 1'b0, 1'b1);
      drain();

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule